// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Bank

This block is a small bank of reservation stations that sits in front of one floating-point execution unit. An issue stage hands it an operation and two source operands. Each operand arrives either as a ready value or as the tag of the station that will produce it. The bank puts the operation into its lowest free station and reports that station's tag back to the issue stage, which uses it for renaming.

Pending operands are filled by watching a shared result bus. Whenever a broadcast tag matches a pending source tag, the station copies the value, so one broadcast can release several stations at once. Stations are independent slots, not a queue. Whenever the unit is idle, the lowest-numbered station whose operands are both present is dispatched, whatever its issue order.

The execution unit is not pipelined and has a fixed latency for each class of operation. Its result is driven on the bank's own result port together with the producing station's tag, and that station becomes free on the same edge. The surrounding logic merges this port onto the shared bus, so stations in the bank can also wait on each other.

Top module: `rs_bank`

## Requirements
- R1: After reset every station is free: `iss_ready` is 1, `iss_tag` is 1 (the first tag with default parameters) and `res_valid` is 0.
- R2: An issue goes to the lowest-numbered free station. Station i carries tag TAG_BASE+i, and this tag is shown on `iss_tag` in the cycle of the issue. Tag value 0 is never used and means "operand ready".
- R3: While every station is busy, `iss_ready` is 0 and an asserted `iss_valid` is ignored: no station is taken and no result ever comes from that request.
- R4: A station waiting on a tag (source tag nonzero) copies `cdb_data` on the edge where `cdb_valid` is high with that tag. One broadcast releases every station waiting on the tag, including stations in this bank that wait on this bank's own results.
- R5: If an issued operand's tag is on the bus in the issue cycle itself, the station stores the broadcast value and does not wait.
- R6: Operation codes: 0 is add, 1 is subtract (j minus k), 2 is multiply and 3 is divide (j divided by k). Results are taken modulo 2^DATA_W, and a division by zero gives all ones.
- R7: For an instruction issued with both operands ready while the unit is idle, `res_valid` is high for exactly one cycle, LAT edges after the issuing edge. LAT is 2 for add and subtract, 10 for multiply and 40 for divide.
- R8: Among the stations that are ready when the unit is idle, the lowest-numbered one is dispatched. A younger ready station passes an older station that is still waiting.
- R9: Only one operation executes at a time. A new dispatch happens only after the current result has gone out, so a ready follower's result comes LAT+1 edges after the previous result.
- R10: The producing station is freed on the edge that ends its result cycle. A full bank shows `iss_ready` = 1 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Operation code (0 add, 1 sub, 2 mul, 3 div) |
| iss_vj | input | DATA_W | First operand value, used when `iss_qj` is 0 |
| iss_qj | input | TAG_W | First operand producer tag, 0 if ready |
| iss_vk | input | DATA_W | Second operand value, used when `iss_qk` is 0 |
| iss_qk | input | TAG_W | Second operand producer tag, 0 if ready |
| iss_ready | output | 1 | A station is free, so an issue is accepted |
| iss_tag | output | TAG_W | Tag of the station an issue in this cycle takes |
| cdb_valid | input | 1 | Shared result bus valid |
| cdb_tag | input | TAG_W | Shared result bus producer tag |
| cdb_data | input | DATA_W | Shared result bus value |
| res_valid | output | 1 | This bank broadcasts a result |
| res_tag | output | TAG_W | Tag of the producing station |
| res_data | output | DATA_W | Result value |

## Verification
Two functions can fall in the same cycle: an issue and a broadcast of the very tag the issue names. The bench provokes this by driving an external broadcast and an issue that waits on its tag in the same cycle, with no broadcast afterwards. It judges the outcome by the issued station's result value and by the fact that the result appears at all. A second collision is the result broadcast itself: the bank's own result is looped back onto the bus, and a dependent station in the bank must capture it on the same edge that frees the producer. This is judged by the dependent division's value and by its timing relative to the multiply.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } rs_op_e;

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N     = 3,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  rs_op_e            in_op,
    input  logic [DATA_W-1:0] in_vj,
    input  logic [TAG_W-1:0]  in_qj,
    input  logic [DATA_W-1:0] in_vk,
    input  logic [TAG_W-1:0]  in_qk,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              grant,
    input  logic              done,
    output logic              busy,
    output logic              ready,
    output logic              exec,
    output rs_op_e            op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk
);
    typedef struct packed {
        logic              busy;
        logic              exec;
        rs_op_e            op;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        logic [TAG_W-1:0]  qj;
        logic [TAG_W-1:0]  qk;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.qj != '0 && cdb_valid && cdb_tag == st_q.qj) begin
                st_d.vj = cdb_data;
                st_d.qj = '0;
            end
            if (st_q.qk != '0 && cdb_valid && cdb_tag == st_q.qk) begin
                st_d.vk = cdb_data;
                st_d.qk = '0;
            end
            if (grant) st_d.exec = 1'b1;
            if (done) begin
                st_d.busy = 1'b0;
                st_d.exec = 1'b0;
            end
        end
        if (alloc) begin
            st_d.busy = 1'b1;
            st_d.exec = 1'b0;
            st_d.op   = in_op;
            st_d.vj   = in_vj;
            st_d.qj   = in_qj;
            st_d.vk   = in_vk;
            st_d.qk   = in_qk;
            // value already on the bus while issuing: take it now
            if (in_qj != '0 && cdb_valid && cdb_tag == in_qj) begin
                st_d.vj = cdb_data;
                st_d.qj = '0;
            end
            if (in_qk != '0 && cdb_valid && cdb_tag == in_qk) begin
                st_d.vk = cdb_data;
                st_d.qk = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = st_q.busy;
    assign exec  = st_q.exec;
    assign ready = st_q.busy && !st_q.exec && st_q.qj == '0 && st_q.qk == '0;
    assign op    = st_q.op;
    assign vj    = st_q.vj;
    assign vk    = st_q.vk;

    // R2
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !st_q.busy);

    // R4
    grant_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (st_q.busy && !st_q.exec && st_q.qj == '0 && st_q.qk == '0));

    // R10
    done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !st_q.busy);
endmodule

// File: rtl/rs_exec.sv
module rs_exec
    import rs_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 2,
    parameter int LAT_AS  = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  rs_op_e            op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [IDX_W-1:0]  idx,
    output logic              busy,
    output logic              res_valid,
    output logic [IDX_W-1:0]  res_idx,
    output logic [DATA_W-1:0] res_data
);
    localparam int LAT_M1 = (LAT_AS > LAT_MUL) ? LAT_AS : LAT_MUL;
    localparam int LAT_MX = (LAT_M1 > LAT_DIV) ? LAT_M1 : LAT_DIV;
    localparam int CNT_W  = $clog2(LAT_MX + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } unit_t;

    unit_t un_d, un_q;

    always_comb begin
        un_d = un_q;
        if (un_q.busy) begin
            if (un_q.cnt == CNT_W'(1)) un_d.busy = 1'b0;
            else                       un_d.cnt  = un_q.cnt - CNT_W'(1);
        end
        if (start) begin
            un_d.busy = 1'b1;
            un_d.idx  = idx;
            unique case (op)
                OP_ADD: begin un_d.data = a + b; un_d.cnt = CNT_W'(LAT_AS);  end
                OP_SUB: begin un_d.data = a - b; un_d.cnt = CNT_W'(LAT_AS);  end
                OP_MUL: begin un_d.data = a * b; un_d.cnt = CNT_W'(LAT_MUL); end
                default: begin
                    un_d.data = (b == '0) ? '1 : a / b;
                    un_d.cnt  = CNT_W'(LAT_DIV);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            un_q <= '0;
        end else begin
            un_q <= un_d;
        end
    end

    assign busy      = un_q.busy;
    assign res_valid = un_q.busy && un_q.cnt == CNT_W'(1);
    assign res_idx   = un_q.idx;
    assign res_data  = un_q.data;

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !un_q.busy);

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

// File: rtl/rs_bank.sv
module rs_bank
    import rs_pkg::*;
#(
    parameter int N_RS     = 3,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 3,
    parameter int TAG_BASE = 1,
    parameter int LAT_AS   = 2,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qk,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data
);
    localparam int IDX_W = (N_RS > 1) ? $clog2(N_RS) : 1;

    logic [N_RS-1:0]   s_busy, s_ready, s_exec, s_alloc, s_grant, s_done;
    rs_op_e            s_op [N_RS];
    logic [DATA_W-1:0] s_vj [N_RS];
    logic [DATA_W-1:0] s_vk [N_RS];

    logic [N_RS-1:0]   free_gnt, disp_req, disp_gnt;
    logic [IDX_W-1:0]  free_idx, disp_idx, res_idx;
    logic              free_any, disp_any, unit_busy;

    rs_pick #(.N(N_RS), .IDX_W(IDX_W)) u_free_pick (
        .req(~s_busy), .gnt(free_gnt), .idx(free_idx), .any(free_any)
    );

    assign disp_req = unit_busy ? '0 : s_ready;

    rs_pick #(.N(N_RS), .IDX_W(IDX_W)) u_disp_pick (
        .req(disp_req), .gnt(disp_gnt), .idx(disp_idx), .any(disp_any)
    );

    assign s_alloc   = iss_valid ? free_gnt : '0;
    assign s_grant   = disp_gnt;
    assign iss_ready = free_any;
    assign iss_tag   = TAG_W'(TAG_BASE) + TAG_W'(free_idx);

    for (genvar i = 0; i < N_RS; i++) begin : g_slot
        assign s_done[i] = res_valid && res_idx == IDX_W'(i);

        rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (s_alloc[i]),
            .in_op    (rs_op_e'(iss_op)),
            .in_vj    (iss_vj),
            .in_qj    (iss_qj),
            .in_vk    (iss_vk),
            .in_qk    (iss_qk),
            .cdb_valid(cdb_valid),
            .cdb_tag  (cdb_tag),
            .cdb_data (cdb_data),
            .grant    (s_grant[i]),
            .done     (s_done[i]),
            .busy     (s_busy[i]),
            .ready    (s_ready[i]),
            .exec     (s_exec[i]),
            .op       (s_op[i]),
            .vj       (s_vj[i]),
            .vk       (s_vk[i])
        );
    end

    rs_exec #(
        .DATA_W(DATA_W), .IDX_W(IDX_W),
        .LAT_AS(LAT_AS), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
    ) u_exec (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (disp_any),
        .op       (s_op[disp_idx]),
        .a        (s_vj[disp_idx]),
        .b        (s_vk[disp_idx]),
        .idx      (disp_idx),
        .busy     (unit_busy),
        .res_valid(res_valid),
        .res_idx  (res_idx),
        .res_data (res_data)
    );

    assign res_tag = TAG_W'(TAG_BASE) + TAG_W'(res_idx);

    // R9
    one_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_exec));

    // R3
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_ready && iss_valid) |=> ($countones(s_busy) >= N_RS - 1));
endmodule

// File: tb/rs_bank_bench.sv
module rs_bank_bench;
    localparam int DW = 16;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [1:0]    iss_op = '0;
    logic [DW-1:0] iss_vj = '0, iss_vk = '0;
    logic [TW-1:0] iss_qj = '0, iss_qk = '0;
    logic          iss_ready;
    logic [TW-1:0] iss_tag;
    logic          ext_valid = 1'b0;
    logic [TW-1:0] ext_tag = '0;
    logic [DW-1:0] ext_data = '0;
    logic          cdb_valid;
    logic [TW-1:0] cdb_tag;
    logic [DW-1:0] cdb_data;
    logic          res_valid;
    logic [TW-1:0] res_tag;
    logic [DW-1:0] res_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    // own result looped onto the shared bus, external producers otherwise
    assign cdb_valid = res_valid | ext_valid;
    assign cdb_tag   = res_valid ? res_tag  : ext_tag;
    assign cdb_data  = res_valid ? res_data : ext_data;

    rs_bank u_rs_bank (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input int vj, input int qj,
                         input int vk, input int qk, output int tag, output bit rdy);
        iss_op = op; iss_vj = DW'(vj); iss_qj = TW'(qj);
        iss_vk = DW'(vk); iss_qk = TW'(qk); iss_valid = 1'b1;
        #1;
        tag = int'(iss_tag);
        rdy = iss_ready;
        tick();
        iss_valid = 1'b0;
    endtask

    task automatic wait_res(output int tag, output int data, output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!res_valid && n < 200);
        tag  = int'(res_tag);
        data = int'(res_data);
    endtask

    task automatic bcast(input int tag, input int data);
        ext_valid = 1'b1; ext_tag = TW'(tag); ext_data = DW'(data);
        tick();
        ext_valid = 1'b0;
    endtask

    // {op, a, b, expected, latency}
    localparam logic [57:0] VEC [6] = '{
        {2'd0, 16'd5,      16'd7,   16'd12,     8'd2},
        {2'd1, 16'd3,      16'd5,   16'hFFFE,   8'd2},
        {2'd2, 16'd300,    16'd300, 16'd24464,  8'd10},
        {2'd3, 16'd100,    16'd7,   16'd14,     8'd40},
        {2'd3, 16'd9,      16'd0,   16'hFFFF,   8'd40},
        {2'd0, 16'hFFFF,   16'd2,   16'd1,      8'd2}
    };

    initial begin
        int tg, dt, n;
        bit rdy;

        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(iss_ready === 1'b1, "R1 iss_ready", int'(iss_ready), 1);
        chk(res_valid === 1'b0, "R1 res_valid", int'(res_valid), 0);
        chk(iss_tag == 3'd1,   "R1 iss_tag", int'(iss_tag), 1);
        tick();

        // table: R6 values, R7 latency
        for (int v = 0; v < 6; v++) begin
            issue(VEC[v][57:56], int'(VEC[v][55:40]), 0, int'(VEC[v][39:24]), 0, tg, rdy);
            chk(tg == 1, "R2 tag of first free", tg, 1);
            wait_res(tg, dt, n);
            chk(dt == int'(VEC[v][23:8]), "R6 result", dt, int'(VEC[v][23:8]));
            chk(n == int'(VEC[v][7:0]), "R7 latency", n, int'(VEC[v][7:0]));
            tick();
        end

        // R2 R3 R4 R10: fill with stations waiting on external tag 7
        issue(2'd0, 0, 7, 1, 0, tg, rdy);
        chk(tg == 1, "R2 tag 1", tg, 1);
        issue(2'd1, 0, 7, 10, 0, tg, rdy);
        chk(tg == 2, "R2 tag 2", tg, 2);
        issue(2'd2, 0, 7, 3, 0, tg, rdy);
        chk(tg == 3, "R2 tag 3", tg, 3);
        issue(2'd0, 1, 0, 1, 0, tg, rdy);   // refused: bank full
        chk(rdy == 1'b0, "R3 iss_ready when full", int'(rdy), 0);
        n = 0;
        for (int c = 0; c < 8; c++) begin
            if (res_valid) n++;
            tick();
        end
        chk(n == 0, "R3 refused issue produced no result", n, 0);
        bcast(7, 20);
        wait_res(tg, dt, n);
        chk(tg == 1 && dt == 21, "R4 first released station", dt, 21);
        tick();
        chk(iss_ready === 1'b1, "R10 freed after result", int'(iss_ready), 1);
        wait_res(tg, dt, n);
        chk(tg == 2 && dt == 10, "R4 second released station", dt, 10);
        wait_res(tg, dt, n);
        chk(tg == 3 && dt == 60, "R4 third released station", dt, 60);
        chk(n == 11, "R9 follower spacing", n, 11);
        tick();
        n = 0;
        for (int c = 0; c < 15; c++) begin
            if (res_valid) n++;
            tick();
        end
        chk(n == 0, "R3 refused issue never executed", n, 0);

        // R5 same-cycle issue and broadcast of tag 6
        ext_valid = 1'b1; ext_tag = 3'd6; ext_data = 16'd50;
        issue(2'd0, 0, 6, 4, 0, tg, rdy);
        ext_valid = 1'b0;
        wait_res(tg, dt, n);
        chk(dt == 54, "R5 same-cycle capture", dt, 54);
        chk(n == 2, "R5 no extra wait", n, 2);
        tick();

        // R8 younger ready station passes older waiting one
        issue(2'd0, 0, 7, 1, 0, tg, rdy);
        issue(2'd1, 9, 0, 4, 0, tg, rdy);
        wait_res(tg, dt, n);
        chk(tg == 2, "R8 younger first tag", tg, 2);
        chk(dt == 5, "R8 younger first value", dt, 5);
        tick();
        bcast(7, 2);
        wait_res(tg, dt, n);
        chk(tg == 1 && dt == 3, "R8 older afterwards", dt, 3);
        tick();

        // R4 R8 R9 chaining on own result: mul -> div waits on tag 1
        issue(2'd2, 6, 0, 7, 0, tg, rdy);
        issue(2'd3, 0, 1, 5, 0, tg, rdy);
        issue(2'd0, 1, 0, 1, 0, tg, rdy);
        wait_res(tg, dt, n);
        chk(tg == 1 && dt == 42, "R6 mul value", dt, 42);
        wait_res(tg, dt, n);
        chk(tg == 2, "R8 lowest ready after mul", tg, 2);
        chk(dt == 8, "R4 div captured own result", dt, 8);
        chk(n == 41, "R9 div after mul spacing", n, 41);
        wait_res(tg, dt, n);
        chk(tg == 3 && dt == 2, "R9 add last", dt, 2);
        chk(n == 3, "R9 add spacing", n, 3);
        tick();

        report();
    end
endmodule